// File: doc/BRIEF.md
# Span Inside/Outside Mask Tree

This block turns a horizontal span, given as left and right pixel offsets inside an aligned zone of 2^n consecutive pixels, into one mask bit per pixel of that zone. A bit is set when its pixel lies inside the span. It is cleared when the pixel belongs to the zone but falls outside the span. The shading datapath interpolates depth and colour for every pixel of the whole zone, and the mask lets the pixels outside the span be discarded before the depth test and the frame-buffer write.

The mask is not built from one pair of magnitude comparators per pixel. A binary tree paints it from the root downward instead. Each node covers an aligned sub-range of the zone and is in one of three states: fully inside the span, fully outside it, or partial. A partial node classifies its two halves by comparing only the address bits that matter at its depth. Inside and outside nodes hand their state straight down. Every tree level has one register stage, so the mask comes out n cycles after its span, in step with an n-stage interpolator. One span can be accepted on every clock.

Top module: `spanmask_tree`

## Requirements
- R1: While `rst_n` is sampled low, the next cycle shows `out_valid` low and `out_mask` all zeros, whatever the inputs carry.
- R2: For a valid span with `in_left` <= `in_right`, mask bit i is 1 exactly when `in_left` <= i <= `in_right`. Bit 0 is the leftmost pixel of the zone, and bit 2^n-1 is the rightmost.
- R3: A valid span with `in_left` > `in_right` yields an all-zero mask.
- R4: `out_valid` goes high exactly `ZONE_LOG2` clock cycles after `in_valid` is sampled high, and the mask it qualifies belongs to that span.
- R5: Spans presented on consecutive cycles come out on consecutive cycles, with no bubble and no mixing between neighbours.
- R6: Whenever `out_valid` is low, `out_mask` is all zeros. The offsets presented with `in_valid` low have no effect on any output.
- R7: A span with `in_left` = `in_right` = k yields a mask with only bit k set.
- R8: The span from 0 to 2^n-1 yields an all-ones mask.
- R9: For a valid span with `in_left` <= `in_right`, the mask has exactly `in_right` - `in_left` + 1 bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Span offsets on this cycle are valid |
| in_left | input | ZONE_LOG2 | Leftmost covered pixel offset, inclusive |
| in_right | input | ZONE_LOG2 | Rightmost covered pixel offset, inclusive |
| out_valid | output | 1 | Mask on this cycle is valid |
| out_mask | output | 2**ZONE_LOG2 | Per-pixel inside flag, bit 0 at left edge of zone |

## Verification
The bench builds the block with `ZONE_LOG2` = 4, a 16-pixel zone with four tree levels. This size is small enough to drive all 256 left/right pairs back to back. The sweep covers every inverted pair, every single-pixel span, the full zone, and every place where a span edge meets a half, quarter or eighth boundary in the tree. Four levels also make the pipeline deep enough that several spans are in flight at once while the latency is checked. Gapped traffic, junk offsets sent with the strobe low, and reset held with the strobe high complete the stimulus.

// File: rtl/spanmask_pkg.sv
// Shared types for the span mask tree.
// Assumes: a node state fits in two bits, and the all-zero code means "outside",
// so a cleared register gives an empty mask.
package spanmask_pkg;

    typedef enum logic [1:0] {
        ST_OUT  = 2'd0,
        ST_IN   = 2'd1,
        ST_PART = 2'd2
    } node_st_t;

endpackage

// File: rtl/spanmask_node.sv
// One child evaluator of the mask tree.
// Classifies the aligned range whose top W address bits equal PREFIX against the
// inclusive span [lo, hi]. A parent that is already fully inside or fully outside
// forces its own state; only a partial parent looks at the bounds.
// Assumes: 1 <= W <= ZONE_LOG2, and the root has already mapped lo > hi to outside.
module spanmask_node
    import spanmask_pkg::*;
#(
    parameter int ZONE_LOG2 = 4,
    parameter int W         = 1,
    parameter int PREFIX    = 0
) (
    input  node_st_t               parent_st,
    input  logic [ZONE_LOG2-1:0]   lo,
    input  logic [ZONE_LOG2-1:0]   hi,
    output node_st_t               child_st
);

    localparam logic [W-1:0] P = W'(PREFIX);

    logic [W-1:0] lo_top;
    logic [W-1:0] hi_top;
    logic         lo_rest_zero;
    logic         hi_rest_ones;
    logic         is_out;
    logic         is_in;

    assign lo_top = lo[ZONE_LOG2-1 -: W];
    assign hi_top = hi[ZONE_LOG2-1 -: W];

    // Lower address bits exist only above the leaf level.
    if (W < ZONE_LOG2) begin : g_inner
        assign lo_rest_zero = (lo[ZONE_LOG2-W-1:0] == '0);
        assign hi_rest_ones = (hi[ZONE_LOG2-W-1:0] == '1);
    end else begin : g_leaf
        assign lo_rest_zero = 1'b1;
        assign hi_rest_ones = 1'b1;
    end

    // Range versus span: disjoint, contained, or straddling an edge.
    always_comb begin
        is_out = (P < lo_top) || (P > hi_top);
        is_in  = ((P > lo_top) || ((P == lo_top) && lo_rest_zero)) &&
                 ((P < hi_top) || ((P == hi_top) && hi_rest_ones));
    end

    // Pass the parent state through unless the parent is partial.
    always_comb begin
        if (parent_st != ST_PART) begin
            child_st = parent_st;
        end else if (is_out) begin
            child_st = ST_OUT;
        end else if (is_in) begin
            child_st = ST_IN;
        end else begin
            child_st = ST_PART;
        end
    end

endmodule

// File: rtl/spanmask_level.sv
// One registered level of the mask tree.
// Takes the 2^LEVEL node states of its level and produces the registered states
// of its 2^(LEVEL+1) children. Child j lies under parent j/2, and its low bit
// selects the left (0) or right (1) half. Also carries the valid flag one stage.
// Assumes: the span bounds reach this level already aligned with st_in.
module spanmask_level
    import spanmask_pkg::*;
#(
    parameter int ZONE_LOG2 = 4,
    parameter int LEVEL     = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        v_in,
    input  logic [ZONE_LOG2-1:0]        lo,
    input  logic [ZONE_LOG2-1:0]        hi,
    input  logic [2*(1<<LEVEL)-1:0]     st_in,
    output logic                        v_out,
    output logic [2*(2<<LEVEL)-1:0]     st_out
);

    localparam int CHILDREN = 2 << LEVEL;

    logic [2*CHILDREN-1:0] child_comb;

    for (genvar j = 0; j < CHILDREN; j++) begin : g_child
        node_st_t par_s;
        node_st_t kid_s;

        assign par_s = node_st_t'(st_in[2*(j>>1) +: 2]);

        spanmask_node #(
            .ZONE_LOG2 (ZONE_LOG2),
            .W         (LEVEL + 1),
            .PREFIX    (j)
        ) u_node (
            .parent_st (par_s),
            .lo        (lo),
            .hi        (hi),
            .child_st  (kid_s)
        );

        assign child_comb[2*j +: 2] = kid_s;
    end

    // Stage register: the child states and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_out <= '0;
            v_out  <= 1'b0;
        end else begin
            st_out <= child_comb;
            v_out  <= v_in;
        end
    end

endmodule

// File: rtl/spanmask_tree.sv
// Span inside/outside mask generator for one zone of 2^ZONE_LOG2 pixels.
// The root state is computed from the raw offsets. Each of the ZONE_LOG2 levels
// then splits every range in two and registers the result. The span bounds follow
// the tree in a parallel delay line. Leaf states become mask bits, and the mask is
// held at zero while the output is not valid.
// Assumes: ZONE_LOG2 >= 1; offsets are inclusive; lo > hi means an empty span.
module spanmask_tree
    import spanmask_pkg::*;
#(
    parameter int ZONE_LOG2 = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [ZONE_LOG2-1:0]          in_left,
    input  logic [ZONE_LOG2-1:0]          in_right,
    output logic                          out_valid,
    output logic [(1<<ZONE_LOG2)-1:0]     out_mask
);

    localparam int ZONE_PIX = 1 << ZONE_LOG2;

    node_st_t root_st;

    // Root classification: empty span, whole zone, or partial.
    always_comb begin
        if (in_left > in_right) begin
            root_st = ST_OUT;
        end else if ((in_left == '0) && (in_right == '1)) begin
            root_st = ST_IN;
        end else begin
            root_st = ST_PART;
        end
    end

    for (genvar k = 0; k < ZONE_LOG2; k++) begin : g_lvl
        logic [ZONE_LOG2-1:0]    lo_k;
        logic [ZONE_LOG2-1:0]    hi_k;
        logic [2*(1<<k)-1:0]     st_k;
        logic                    v_k;
        logic [2*(2<<k)-1:0]     st_o;
        logic                    v_o;

        if (k == 0) begin : g_head
            assign lo_k = in_left;
            assign hi_k = in_right;
            assign st_k = root_st;
            assign v_k  = in_valid;
        end else begin : g_body
            assign lo_k = g_lvl[k-1].g_fwd.lo_d;
            assign hi_k = g_lvl[k-1].g_fwd.hi_d;
            assign st_k = g_lvl[k-1].st_o;
            assign v_k  = g_lvl[k-1].v_o;
        end

        // Every level but the last forwards the bounds to the next level.
        if (k < ZONE_LOG2 - 1) begin : g_fwd
            logic [ZONE_LOG2-1:0] lo_d;
            logic [ZONE_LOG2-1:0] hi_d;

            // Bound delay register, kept in step with the tree level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_d <= '0;
                    hi_d <= '0;
                end else begin
                    lo_d <= lo_k;
                    hi_d <= hi_k;
                end
            end
        end

        spanmask_level #(
            .ZONE_LOG2 (ZONE_LOG2),
            .LEVEL     (k)
        ) u_level (
            .clk    (clk),
            .rst_n  (rst_n),
            .v_in   (v_k),
            .lo     (lo_k),
            .hi     (hi_k),
            .st_in  (st_k),
            .v_out  (v_o),
            .st_out (st_o)
        );
    end

    logic [2*ZONE_PIX-1:0] leaf_st;

    assign leaf_st   = g_lvl[ZONE_LOG2-1].st_o;
    assign out_valid = g_lvl[ZONE_LOG2-1].v_o;

    // Leaf states to mask bits, gated by the output valid.
    always_comb begin
        for (int i = 0; i < ZONE_PIX; i++) begin
            out_mask[i] = out_valid && (leaf_st[2*i +: 2] == ST_IN);
        end
    end

endmodule

// File: rtl/spanmask_tree_chk.sv
// Property checker for spanmask_tree, attached with bind.
// Keeps its own delay line of the input span, ZONE_LOG2 deep, and relates each
// output mask to the span that produced it.
// Assumes: the same synchronous active-low reset as the design.
module spanmask_tree_chk #(
    parameter int ZONE_LOG2 = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [ZONE_LOG2-1:0]          in_left,
    input logic [ZONE_LOG2-1:0]          in_right,
    input logic                          out_valid,
    input logic [(1<<ZONE_LOG2)-1:0]     out_mask
);

    localparam int ZP = 1 << ZONE_LOG2;
    localparam int LAST = ZONE_LOG2 - 1;

    logic                 dv [ZONE_LOG2];
    logic [ZONE_LOG2-1:0] dl [ZONE_LOG2];
    logic [ZONE_LOG2-1:0] dh [ZONE_LOG2];
    logic [ZP-1:0]        one_hot;

    // Delay line of the offered span, as deep as the design's latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ZONE_LOG2; k++) begin
                dv[k] <= 1'b0;
                dl[k] <= '0;
                dh[k] <= '0;
            end
        end else begin
            dv[0] <= in_valid;
            dl[0] <= in_left;
            dh[0] <= in_right;
            for (int k = 1; k < ZONE_LOG2; k++) begin
                dv[k] <= dv[k-1];
                dl[k] <= dl[k-1];
                dh[k] <= dh[k-1];
            end
        end
    end

    assign one_hot = {{(ZP-1){1'b0}}, 1'b1} << dl[LAST];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_mask == '0))); // R1

    AST_EDGE_PIXELS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (dl[LAST] <= dh[LAST])) |-> (out_mask[dl[LAST]] && out_mask[dh[LAST]])); // R2

    AST_INVERTED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (dl[LAST] > dh[LAST])) |-> (out_mask == '0)); // R3

    AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == dv[LAST]); // R4

    AST_IDLE_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_mask == '0)); // R6

    AST_SINGLE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (dl[LAST] == dh[LAST])) |-> (out_mask == one_hot)); // R7

    AST_FULL_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (dl[LAST] == '0) && (dh[LAST] == '1)) |-> (out_mask == '1)); // R8

    AST_SPAN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (dl[LAST] <= dh[LAST])) |->
        ($countones(out_mask) == (int'(dh[LAST]) - int'(dl[LAST]) + 1))); // R9

endmodule

bind spanmask_tree spanmask_tree_chk #(.ZONE_LOG2(ZONE_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_mask  (out_mask)
);

// File: tb/spanmask_tree_tb_top.sv
// Bench for spanmask_tree. A behavioural model keeps a queue of expected
// outputs, ZONE_LOG2 deep, and compares the outputs on every falling clock edge.
module spanmask_tree_tb_top;

    localparam int NL = 4;
    localparam int NP = 1 << NL;

    typedef struct {
        bit          v;
        int          l;
        int          r;
        logic [NP-1:0] m;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NL-1:0] in_left = '0;
    logic [NL-1:0] in_right = '0;
    logic          out_valid;
    logic [NP-1:0] out_mask;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string vtag = "R4";
    exp_t  q[$];

    always #10 clk = ~clk;

    spanmask_tree #(.ZONE_LOG2(NL)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_valid (out_valid),
        .out_mask  (out_mask)
    );

    function automatic logic [NP-1:0] ref_mask(input int l, input int r);
        logic [NP-1:0] m = '0;
        for (int i = 0; i < NP; i++) begin
            if (l <= i && i <= r) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic string mask_tag(input int l, input int r);
        if (l > r) return "R3";
        if (l == r) return "R7";
        if (l == 0 && r == NP - 1) return "R8";
        return "R2";
    endfunction

    task automatic check_one(input exp_t e);
        checks++;
        if (out_valid !== e.v) begin
            fails++;
            $display("FAIL %s: out_valid got %b expected %b", vtag, out_valid, e.v);
        end
        checks++;
        if (e.v) begin
            if (out_mask !== e.m) begin
                fails++;
                $display("FAIL %s: span [%0d,%0d] mask got %h expected %h",
                         mask_tag(e.l, e.r), e.l, e.r, out_mask, e.m);
            end
            checks++;
            // R9: set-bit count equals span length
            if ($countones(out_mask) != ((e.l <= e.r) ? (e.r - e.l + 1) : 0)) begin
                fails++;
                $display("FAIL R9: span [%0d,%0d] count got %0d expected %0d", e.l, e.r,
                         $countones(out_mask), (e.l <= e.r) ? (e.r - e.l + 1) : 0);
            end
        end else if (out_mask !== '0) begin
            fails++;
            $display("FAIL R6: idle mask got %h expected %h", out_mask, {NP{1'b0}});
        end
    endtask

    task automatic step(input bit v, input int l, input int r);
        exp_t e;
        @(negedge clk);
        check_one(q.pop_front());
        in_valid = v;
        in_left  = NL'(l);
        in_right = NL'(r);
        e.v = v;
        e.l = l;
        e.r = r;
        e.m = v ? ref_mask(l, r) : '0;
        q.push_back(e);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: cycles got %0d expected below %0d", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        exp_t idle;
        idle.v = 1'b0;
        idle.l = 0;
        idle.r = 0;
        idle.m = '0;

        // R1: reset is held while valid junk spans are offered.
        in_valid = 1'b1;
        in_left  = 4'd2;
        in_right = 4'd9;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_mask !== '0) begin
                fails++;
                $display("FAIL R1: valid/mask got %b/%h expected 0/%h",
                         out_valid, out_mask, {NP{1'b0}});
            end
        end
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < NL; i++) q.push_back(idle);

        // R5: every left/right pair, back to back (covers R2, R3, R7, R8).
        vtag = "R5";
        for (int l = 0; l < NP; l++) begin
            for (int r = 0; r < NP; r++) begin
                step(1'b1, l, r);
            end
        end

        // R4, R6: gapped traffic, with junk offsets while the strobe is low.
        vtag = "R4";
        step(1'b0, 3, 12);
        step(1'b1, 3, 9);
        step(1'b0, 0, 15);
        step(1'b0, 15, 0);
        step(1'b1, 9, 3);
        step(1'b0, 1, 1);
        step(1'b1, 0, 15);
        step(1'b1, 7, 8);
        step(1'b0, 4, 4);
        step(1'b0, 6, 10);
        step(1'b0, 2, 2);
        step(1'b1, 15, 15);
        step(1'b1, 0, 0);
        step(1'b0, 0, 7);
        step(1'b1, 8, 15);
        for (int i = 0; i < NL + 3; i++) step(1'b0, 5, 11);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule